// File: doc/BRIEF.md
# PLL Feedback Divider Ramp Controller

This block changes the feedback divider value N of a PLL that is already running, and it does so without dropping lock. It does not load the divider in one step. It drives the PLL's slowdown and dynamic-ramp controls through a fixed sequence, and the analog loop moves to the new ratio gradually. The input divider and post divider are not touched: the block drives only the N field of the coefficient word.

A client issues a one-cycle request that carries the target N. The block compares the target with the N currently programmed. If the two match, it reports success and does nothing else. Otherwise it runs these steps in order:

1. Load both ramp step sizes.
2. Enable slowdown.
3. Write the new N.
4. Wait for one microsecond tick, then enable the dynamic ramp.
5. Poll the synchronised ramp-done status once per microsecond tick, up to a bounded number of polls.
6. Drop both enables.
7. Report success, or report a timeout if done was never seen.

A free-running microsecond tick input paces every wait.

Top module: `ndiv_ramp_ctrl`

## Requirements
- R1: After reset, `slow_en` and `ramp_en` are 0, `step_a` and `step_b` are 0, `n_coef` equals the parameter `N_RST` (40 by default), and `res_valid` is 0.
- R2: A request whose `req_n` equals `cur_n` produces a `res_valid` pulse with `res_timeout`=0. No step, enable or `n_coef` output changes.
- R3: Before `slow_en` rises, `step_a` holds 0x2B and `step_b` holds 0x0B. Both keep those values afterwards.
- R4: `n_coef` changes only while `slow_en` is 1 and `ramp_en` is 0. After a differing request it ends at the requested N.
- R5: `ramp_en` rises only on a clock edge where `us_tick` is 1 and `slow_en` is already 1. It stays 0 whenever `slow_en` is 0.
- R6: While ramping, `ramp_done_async` is sampled through a two-flop synchroniser once per `us_tick`. Once done is seen within the poll limit, the result is success (`res_timeout`=0).
- R7: If done is not seen within `POLLS` polls (500 by default), the block stops after exactly `POLLS` polls and reports `res_timeout`=1.
- R8: On exit, `slow_en` and `ramp_en` fall on the same edge, and this happens whether or not done was seen. `res_valid` is a single-cycle pulse that follows with both enables already 0.
- R9: While `busy` is 1, a request has no effect. It does not change `n_coef` and it does not produce an extra result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| req_valid | input | 1 | Request strobe |
| req_n | input | NW | Target feedback divider |
| cur_n | input | NW | Feedback divider currently programmed |
| ramp_done_async | input | 1 | Ramp-complete status from the PLL, asynchronous |
| step_a | output | SW | First ramp step size |
| step_b | output | SW | Second ramp step size |
| slow_en | output | 1 | Slowdown mode enable |
| ramp_en | output | 1 | Dynamic ramp enable |
| n_coef | output | NW | N field of the coefficient word |
| busy | output | 1 | Sequence in progress; requests are ignored |
| res_valid | output | 1 | Result pulse |
| res_timeout | output | 1 | Result: 1 means ramp timeout |

## Verification
Some faults in the sequence state show up at once as an ordering error at the ports. Examples are `n_coef` moving before slowdown is on, `ramp_en` rising without a tick, and enables that stay high when the result pulses. Such faults are visible within a cycle of the bad transition.

A poll counter that is off by one changes the tick count seen while `ramp_en` is high on the timeout path. That error appears only when the result arrives, about 500 ticks later.

A latch that takes requests while busy shows up as a result the scoreboard did not expect, or as a final `n_coef` that differs from the first request.

// File: rtl/ndiv_ramp_ctrl.sv
module ndiv_ramp_ctrl #(
  parameter int NW = 8,
  parameter int SW = 8,
  parameter int POLLS = 500,
  parameter logic [SW-1:0] STEP_A = 8'h2B,
  parameter logic [SW-1:0] STEP_B = 8'h0B,
  parameter logic [NW-1:0] N_RST = 8'd40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          us_tick,
  input  logic          req_valid,
  input  logic [NW-1:0] req_n,
  input  logic [NW-1:0] cur_n,
  input  logic          ramp_done_async,
  output logic [SW-1:0] step_a,
  output logic [SW-1:0] step_b,
  output logic          slow_en,
  output logic          ramp_en,
  output logic [NW-1:0] n_coef,
  output logic          busy,
  output logic          res_valid,
  output logic          res_timeout
);
  localparam int CW = $clog2(POLLS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CFG, S_SLOW, S_WRN, S_SETTLE, S_POLL, S_EXIT, S_REPORT
  } st_t;

  st_t           st;
  logic [1:0]    sync_q;
  logic [NW-1:0] tgt;
  logic [CW-1:0] polls;
  logic          to_q;
  wire           done_s = sync_q[1];

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], ramp_done_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      tgt         <= '0;
      polls       <= '0;
      to_q        <= 1'b0;
      step_a      <= '0;
      step_b      <= '0;
      slow_en     <= 1'b0;
      ramp_en     <= 1'b0;
      n_coef      <= N_RST;
      res_valid   <= 1'b0;
      res_timeout <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          tgt <= req_n;
          if (req_n == cur_n) begin
            to_q <= 1'b0;
            st   <= S_REPORT;
          end else begin
            st <= S_CFG;
          end
        end
        S_CFG: begin
          step_a <= STEP_A;
          step_b <= STEP_B;
          st     <= S_SLOW;
        end
        S_SLOW: begin
          slow_en <= 1'b1;
          st      <= S_WRN;
        end
        S_WRN: begin
          n_coef <= tgt;
          st     <= S_SETTLE;
        end
        S_SETTLE: if (us_tick) begin
          ramp_en <= 1'b1;
          polls   <= '0;
          st      <= S_POLL;
        end
        S_POLL: if (us_tick) begin
          if (done_s) begin
            to_q <= 1'b0;
            st   <= S_EXIT;
          end else if (polls == CW'(POLLS - 1)) begin
            to_q <= 1'b1;
            st   <= S_EXIT;
          end else begin
            polls <= polls + 1'b1;
          end
        end
        S_EXIT: begin
          slow_en <= 1'b0;
          ramp_en <= 1'b0;
          st      <= S_REPORT;
        end
        S_REPORT: begin
          res_valid   <= 1'b1;
          res_timeout <= to_q;
          st          <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ndiv_ramp_ctrl_chk.sv
module ndiv_ramp_ctrl_chk #(
  parameter int NW = 8,
  parameter int SW = 8,
  parameter logic [SW-1:0] STEP_A = 8'h2B,
  parameter logic [SW-1:0] STEP_B = 8'h0B
) (
  input logic          clk,
  input logic          rst_n,
  input logic          us_tick,
  input logic          slow_en,
  input logic          ramp_en,
  input logic [NW-1:0] n_coef,
  input logic [SW-1:0] step_a,
  input logic [SW-1:0] step_b,
  input logic          res_valid
);
  assert_steps_before_slow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slow_en) |-> (step_a == STEP_A && step_b == STEP_B));

  assert_n_in_slowdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_coef) |-> (slow_en && !ramp_en));

  assert_ramp_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_en) |-> ($past(us_tick) && slow_en));

  assert_ramp_needs_slow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en |-> slow_en);

  assert_exit_together_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slow_en) |-> !ramp_en);

  assert_result_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (!slow_en && !ramp_en));

  assert_result_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

bind ndiv_ramp_ctrl ndiv_ramp_ctrl_chk #(
  .NW(NW), .SW(SW), .STEP_A(STEP_A), .STEP_B(STEP_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .slow_en(slow_en),
  .ramp_en(ramp_en), .n_coef(n_coef), .step_a(step_a), .step_b(step_b),
  .res_valid(res_valid)
);

// File: tb/ndiv_ramp_ctrl_bench.sv
module ndiv_ramp_ctrl_bench;
  localparam int NW = 8;
  localparam int SW = 8;
  localparam int POLLS = 500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0;
  logic req_valid = 1'b0;
  logic [NW-1:0] req_n = '0;
  logic ramp_done_async;
  logic [SW-1:0] step_a, step_b;
  logic slow_en, ramp_en, busy, res_valid, res_timeout;
  logic [NW-1:0] n_coef;

  int n_chk = 0;
  int n_bad = 0;
  int done_after = 1000000;
  int rticks = 0;
  int polls_seen = 0;
  logic [NW:0] exp_q[$];

  always #2 clk = ~clk;

  ndiv_ramp_ctrl u_ndiv_ramp_ctrl (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .req_valid(req_valid),
    .req_n(req_n), .cur_n(n_coef), .ramp_done_async(ramp_done_async),
    .step_a(step_a), .step_b(step_b), .slow_en(slow_en), .ramp_en(ramp_en),
    .n_coef(n_coef), .busy(busy), .res_valid(res_valid), .res_timeout(res_timeout)
  );

  // tick generator: one pulse every 4 cycles
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      us_tick = 1'b1;
      @(negedge clk);
      us_tick = 1'b0;
    end
  end

  // PLL ramp model
  always @(posedge clk) begin
    if (!ramp_en) rticks <= 0;
    else if (us_tick) rticks <= rticks + 1;
    if (ramp_en && us_tick) polls_seen <= polls_seen + 1;
  end
  assign ramp_done_async = ramp_en && (rticks >= done_after);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected result", 32'd1, 32'd0);
      end else begin
        logic [NW:0] e;
        e = exp_q.pop_front();
        check("R6/R7 timeout flag", {31'd0, res_timeout}, {31'd0, e[NW]});
        check("R4 final n_coef", {24'd0, n_coef}, {24'd0, e[NW-1:0]});
        check("R8 enables off at result", {30'd0, slow_en, ramp_en}, 32'd0);
      end
    end
  end

  task automatic do_req(logic [NW-1:0] n, int after, logic exp_to, logic [NW-1:0] exp_n);
    while (busy || res_valid) @(negedge clk);
    done_after = after;
    polls_seen = 0;
    exp_q.push_back({exp_to, exp_n});
    req_n = n;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 slow_en", {31'd0, slow_en}, 32'd0);
    check("R1 ramp_en", {31'd0, ramp_en}, 32'd0);
    check("R1 steps", {16'd0, step_a, step_b}, 32'd0);
    check("R1 n_coef", {24'd0, n_coef}, 32'd40);
    check("R1 res_valid", {31'd0, res_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: equal N, nothing moves
    do_req(8'd40, 1, 1'b0, 8'd40);
    check("R2 steps untouched", {16'd0, step_a, step_b}, 32'd0);
    check("R2 no ramp polls", polls_seen, 0);

    // R3 R6: fast done
    do_req(8'd100, 3, 1'b0, 8'd100);
    check("R3 step_a", {24'd0, step_a}, 32'h2B);
    check("R3 step_b", {24'd0, step_b}, 32'h0B);
    check("R6 polled some", {31'd0, polls_seen > 0 && polls_seen < 10}, 32'd1);

    // R6: late done
    do_req(8'd60, 450, 1'b0, 8'd60);
    check("R6 late done before limit", {31'd0, polls_seen <= POLLS}, 32'd1);

    // R9: second request while busy is ignored
    fork
      do_req(8'd200, 10, 1'b0, 8'd200);
      begin
        repeat (8) @(negedge clk);
        check("R9 busy during ramp", {31'd0, busy}, 32'd1);
        req_n = 8'd7;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_n = 8'd200;
      end
    join
    repeat (20) @(negedge clk);
    check("R9 n_coef kept", {24'd0, n_coef}, 32'd200);

    // R7: never done, timeout after exactly POLLS polls
    do_req(8'd30, 1000000, 1'b1, 8'd30);
    check("R7 poll count", polls_seen, POLLS);
    check("R7 slowdown exited", {30'd0, slow_en, ramp_en}, 32'd0);

    // R2 again after a timeout
    do_req(8'd30, 1, 1'b0, 8'd30);
    repeat (10) @(negedge clk);
    check("R9 no stray results", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule